// File: doc/BRIEF.md
# ADC Result Buffer with Byte-Serial Readout

This block sits between the conversion engine of a multi-channel converter and its serial port. It holds up to sixteen 10-bit conversion results in a circular queue and one temperature result in a slot of its own. Each entry is kept as a 16-bit word: four zero bits, the ten result bits and then two sub-bits. A host reads the word out one byte at a time. A falling edge on the active-low select starts a read, and each serial clock period moves one bit onto the data line, most significant bit first.

When the queue is full, a new conversion result pushes out the oldest stored result, so the newest data is always kept. An unread temperature result is always sent before any queued conversion result. The block keeps track of which byte of the current word comes next, and that position survives across select cycles. If nothing is stored, or the select is high, the data line is held low. Select and serial clock are sampled by the block clock, which must run several times faster than the serial clock.

Top module: `adc_result_readout`

## Requirements
- R1: After reset, res_count is 0, tmp_valid is 0 and sdo is 0.
- R2: Every res_wr pulse stores one result. res_count reports how many results are stored, up to DEPTH (16).
- R3: A res_wr while DEPTH results are stored drops the oldest result and keeps the new one. res_count stays at DEPTH.
- R4: A stored word is {4'b0000, data[9:0], sub[1:0]}. The high byte (word bits 15:8) is sent before the low byte (bits 7:0), and each byte is sent bit 7 first.
- R5: A falling edge on cs_n resets the bit position to bit 7 of the pending byte. sdo changes only after a falling edge of sclk, so it is stable when sclk rises. Eight sclk falling edges complete one byte.
- R6: sdo is 0 whenever cs_n is high, or when neither a result nor a temperature value is stored.
- R7: While tmp_valid is 1, the next word read is the temperature word (same format as R4), ahead of any queued result.
- R8: A word leaves storage only after both of its bytes have been sent. The position of the next byte is kept across cs_n cycles, so a word read over two select cycles comes out complete and in order.
- R9: If cs_n rises before a byte is complete, that byte is abandoned. The same byte is sent again from bit 7 after the next cs_n falling edge.
- R10: A tmp_wr replaces any unread temperature value and sets tmp_valid. tmp_valid clears once both temperature bytes have been sent.
- R11: If a result is written in the same cycle that a word is removed, res_count does not change. When the queue is full, the read position advances only once, so the next word read is the second-oldest result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; cs_n and sclk are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| res_wr | input | 1 | One-cycle strobe that stores a conversion result |
| res_data | input | 10 | Conversion result |
| res_sub | input | 2 | Sub-bits of the conversion result |
| tmp_wr | input | 1 | One-cycle strobe that loads the temperature slot |
| tmp_data | input | 10 | Temperature result |
| tmp_sub | input | 2 | Sub-bits of the temperature result |
| cs_n | input | 1 | Active-low read select |
| sclk | input | 1 | Serial shift clock |
| sdo | output | 1 | Serial data out |
| res_count | output | 5 | Number of stored conversion results |
| tmp_valid | output | 1 | An unread temperature result is present |

## Verification
The bench writes eighteen results into the sixteen-entry queue. A design that drops new data instead of the oldest entry would return result 0 first instead of result 2. It reads one word across two select cycles and cuts another byte off after three bits. A design that loses the byte position would repeat or skip a byte, and one that counts the abandoned bits as sent would return a shifted byte. It also sends a result write in the same cycle as the final shift edge of a word while the queue is full. Advancing the read position twice there would skip a result, and counting twice would move res_count off 16. A temperature word loaded after queued results must come out first, and a second temperature write must replace the first.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int RES_W  = 10;
  localparam int SUB_W  = 2;
  localparam int PAD_W  = 4;
  localparam int WORD_W = PAD_W + RES_W + SUB_W;
  localparam int BYTE_W = 8;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t pack_word(input logic [RES_W-1:0] d,
                                      input logic [SUB_W-1:0] s);
    return {{PAD_W{1'b0}}, d, s};
  endfunction
endpackage

// File: rtl/afr_ring.sv
module afr_ring
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  word_t         wr_word,
  input  logic          pop,
  output word_t         head_word,
  output logic [CW-1:0] count
);

  word_t          mem [DEPTH];
  logic [AW-1:0]  rd_ptr, rd_ptr_n;
  logic [AW-1:0]  wr_ptr, wr_ptr_n;
  logic [CW-1:0]  count_n;
  logic           full, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign do_pop = pop && (count != '0);

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (wr_en) wr_ptr_n = step(wr_ptr);
    if (do_pop || (wr_en && full)) rd_ptr_n = step(rd_ptr);
    unique case ({wr_en, do_pop})
      2'b10:   count_n = full ? count : count + 1'b1;
      2'b01:   count_n = count - 1'b1;
      default: count_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_n;
      wr_ptr <= wr_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  assign head_word = mem[rd_ptr];

  // R2: occupancy never exceeds the queue depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R3: writing into a full queue keeps it full
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> full);

  // R11: write together with removal leaves occupancy unchanged
  a_r11_write_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && do_pop) |=> (count == $past(count)));

  // R11: full queue with write and removal advances the read side once
  a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && do_pop) |=> (rd_ptr == step($past(rd_ptr))));

endmodule

// File: rtl/afr_temp_slot.sv
module afr_temp_slot
  import adc_fifo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wr_word,
  input  logic  pop,
  output logic  vld,
  output word_t word_q
);

  logic  vld_n;
  word_t word_n;

  always_comb begin
    vld_n  = vld;
    word_n = word_q;
    if (wr_en) begin
      vld_n  = 1'b1;
      word_n = wr_word;
    end else if (pop) begin
      vld_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      word_q <= '0;
    end else begin
      vld    <= vld_n;
      word_q <= word_n;
    end
  end

  // R10: sending both bytes without a new load clears the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_en) |=> !vld);

  // R10: a load always leaves a valid temperature value
  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld);

endmodule

// File: rtl/afr_serial_seq.sv
module afr_serial_seq
  import adc_fifo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  sclk,
  input  logic  avail,
  input  word_t word,
  output logic  pop,
  output logic  sdo
);

  logic       cs_q, sclk_q;
  logic [2:0] bitcnt, bitcnt_n;
  logic       lo_next, lo_next_n;
  logic       cs_fall, sclk_fall, byte_done;
  logic [BYTE_W-1:0] cur_byte;

  assign cs_fall   = cs_q && !cs_n;
  assign sclk_fall = sclk_q && !sclk && !cs_n;
  assign byte_done = sclk_fall && avail && (bitcnt == 3'd7);
  assign pop       = byte_done && lo_next;

  always_comb begin
    bitcnt_n  = bitcnt;
    lo_next_n = lo_next;
    if (cs_fall) begin
      bitcnt_n = '0;
    end else if (sclk_fall && avail) begin
      bitcnt_n = bitcnt + 1'b1;
      if (byte_done) lo_next_n = !lo_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      bitcnt  <= '0;
      lo_next <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      sclk_q  <= sclk;
      bitcnt  <= bitcnt_n;
      lo_next <= lo_next_n;
    end
  end

  assign cur_byte = lo_next ? word[BYTE_W-1:0] : word[WORD_W-1:BYTE_W];
  assign sdo      = (!cs_n && avail) ? cur_byte[3'd7 - bitcnt] : 1'b0;

  // R5: every select falling edge restarts at bit 7
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (bitcnt == 3'd0));

  // R8: a word leaves only after its low byte, then the high byte is next
  a_r8_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !lo_next);

endmodule

// File: rtl/adc_result_readout.sv
module adc_result_readout
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_wr,
  input  logic [RES_W-1:0] res_data,
  input  logic [SUB_W-1:0] res_sub,
  input  logic             tmp_wr,
  input  logic [RES_W-1:0] tmp_data,
  input  logic [SUB_W-1:0] tmp_sub,
  input  logic             cs_n,
  input  logic             sclk,
  output logic             sdo,
  output logic [CW-1:0]    res_count,
  output logic             tmp_valid
);

  logic  rst_meta, rst_s;
  word_t head_word, tmp_word, out_word;
  logic  seq_pop, avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  afr_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_en     (res_wr),
    .wr_word   (pack_word(res_data, res_sub)),
    .pop       (seq_pop && !tmp_valid),
    .head_word (head_word),
    .count     (res_count)
  );

  afr_temp_slot u_temp (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (tmp_wr),
    .wr_word (pack_word(tmp_data, tmp_sub)),
    .pop     (seq_pop && tmp_valid),
    .vld     (tmp_valid),
    .word_q  (tmp_word)
  );

  assign avail    = tmp_valid || (res_count != '0);
  assign out_word = tmp_valid ? tmp_word : head_word;

  afr_serial_seq u_seq (
    .clk   (clk),
    .rst_n (rst_s),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .avail (avail),
    .word  (out_word),
    .pop   (seq_pop),
    .sdo   (sdo)
  );

  // R6: an idle select keeps the data line low
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_s)
    cs_n |-> !sdo);

endmodule

// File: tb/adc_result_readout_bench.sv
`timescale 1ns/1ps
module adc_result_readout_bench;
  logic       clk = 1'b0;
  logic       rst_n, res_wr, tmp_wr, cs_n, sclk, sdo, tmp_valid;
  logic [9:0] res_data, tmp_data;
  logic [1:0] res_sub, tmp_sub;
  logic [4:0] res_count;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  adc_result_readout u_adc_result_readout (
    .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_data(res_data),
    .res_sub(res_sub), .tmp_wr(tmp_wr), .tmp_data(tmp_data),
    .tmp_sub(tmp_sub), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
    .res_count(res_count), .tmp_valid(tmp_valid)
  );

  function automatic logic [15:0] mk(input logic [9:0] d, input logic [1:0] s);
    return {4'b0000, d, s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] d, input logic [1:0] s);
    @(negedge clk) res_wr = 1'b1; res_data = d; res_sub = s;
    @(negedge clk) res_wr = 1'b0;
  endtask

  task automatic push_tmp(input logic [9:0] d, input logic [1:0] s);
    @(negedge clk) tmp_wr = 1'b1; tmp_data = d; tmp_sub = s;
    @(negedge clk) tmp_wr = 1'b0;
  endtask

  task automatic sel(input logic v);
    @(negedge clk) cs_n = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic shift_bits(input int n, input bit wr_last, input logic [9:0] wd,
                            output logic [7:0] b);
    b = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk = 1'b1;
      repeat (2) @(negedge clk);
      b[7-i] = sdo;
      @(negedge clk) sclk = 1'b0;
      if (wr_last && i == n - 1) begin
        res_wr = 1'b1; res_data = wd; res_sub = 2'b01;
      end
      @(negedge clk) res_wr = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] hi, lo;
    sel(1'b0);
    shift_bits(8, 1'b0, '0, hi);
    shift_bits(8, 1'b0, '0, lo);
    sel(1'b1);
    w = {hi, lo};
  endtask

  task automatic t_reset();
    check("R1 count", res_count, 0);
    check("R1 tmp_valid", tmp_valid, 0);
    check("R1 sdo", sdo, 0);
  endtask

  task automatic t_basic();
    logic [15:0] w;
    push(10'h3A5, 2'b10); push(10'h001, 2'b01); push(10'h200, 2'b11);
    check("R2 count", res_count, 3);
    read_word(w); check("R4 word0", w, mk(10'h3A5, 2'b10));
    read_word(w); check("R4 R5 word1", w, mk(10'h001, 2'b01));
    read_word(w); check("R8 word2", w, mk(10'h200, 2'b11));
    check("R2 drained", res_count, 0);
  endtask

  task automatic t_empty();
    logic [7:0] b;
    sel(1'b0);
    shift_bits(8, 1'b0, '0, b);
    sel(1'b1);
    check("R6 empty byte", b, 0);
    push(10'h3FF, 2'b11);
    check("R6 cs high", sdo, 0);
    read_word(w_dummy);
  endtask
  logic [15:0] w_dummy;

  task automatic t_overflow();
    logic [15:0] w;
    for (int i = 0; i < 18; i++) push(10'(i * 37 + 5), 2'(i));
    check("R3 count", res_count, 16);
    read_word(w); check("R3 oldest dropped", w, mk(10'(2 * 37 + 5), 2'(2)));
    for (int i = 3; i < 18; i++) read_word(w);
    check("R3 newest kept", w, mk(10'(17 * 37 + 5), 2'(17)));
    check("R3 drained", res_count, 0);
  endtask

  task automatic t_temp();
    logic [15:0] w;
    push(10'h111, 2'b00); push(10'h222, 2'b01);
    push_tmp(10'h155, 2'b10);
    check("R10 valid set", tmp_valid, 1);
    read_word(w); check("R7 temp first", w, mk(10'h155, 2'b10));
    check("R10 valid clear", tmp_valid, 0);
    check("R7 queue untouched", res_count, 2);
    push_tmp(10'h0AA, 2'b01); push_tmp(10'h2CC, 2'b11);
    read_word(w); check("R10 replaced", w, mk(10'h2CC, 2'b11));
    read_word(w); check("R7 queue after temp", w, mk(10'h111, 2'b00));
    read_word(w);
  endtask

  task automatic t_split();
    logic [7:0] hi, lo;
    push(10'h2B7, 2'b10);
    sel(1'b0); shift_bits(8, 1'b0, '0, hi); sel(1'b1);
    check("R8 kept after one byte", res_count, 1);
    sel(1'b0); shift_bits(8, 1'b0, '0, lo); sel(1'b1);
    check("R8 split word", {hi, lo}, mk(10'h2B7, 2'b10));
    check("R8 removed", res_count, 0);
  endtask

  task automatic t_abort();
    logic [7:0] part, hi, lo;
    push(10'h19C, 2'b01);
    sel(1'b0); shift_bits(3, 1'b0, '0, part); sel(1'b1);
    sel(1'b0);
    shift_bits(8, 1'b0, '0, hi);
    shift_bits(8, 1'b0, '0, lo);
    sel(1'b1);
    check("R9 byte repeated", hi, 8'(mk(10'h19C, 2'b01) >> 8));
    check("R9 low byte", lo, 8'(mk(10'h19C, 2'b01)));
  endtask

  task automatic t_simul();
    logic [7:0] hi, lo;
    logic [15:0] w;
    for (int i = 0; i < 16; i++) push(10'(100 + i), 2'b00);
    sel(1'b0);
    shift_bits(8, 1'b0, '0, hi);
    shift_bits(8, 1'b1, 10'h3C3, lo);
    sel(1'b1);
    check("R11 word0", {hi, lo}, mk(10'd100, 2'b00));
    check("R11 count full", res_count, 16);
    read_word(w); check("R11 single advance", w, mk(10'd101, 2'b00));
    for (int i = 2; i < 16; i++) read_word(w);
    read_word(w); check("R11 new last", w, mk(10'h3C3, 2'b01));
  endtask

  initial begin
    rst_n = 1'b0; res_wr = 1'b0; tmp_wr = 1'b0; cs_n = 1'b1; sclk = 1'b0;
    res_data = '0; res_sub = '0; tmp_data = '0; tmp_sub = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_empty();
    t_overflow();
    t_temp();
    t_split();
    t_abort();
    t_simul();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule